// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a 32-bit synchronous burst SRAM with a small internal array (256 words by default). Every command input is captured on the rising clock edge: address, write data, three chip enables, a processor-side and a controller-side address strobe, a burst-advance control and the write controls. The write controls are a global write, a byte-write enable and four per-lane enables. A burst starts on either strobe. Its two low address bits preset a 2-bit beat counter, which then steps in linear order or in XOR-interleaved order. Output-enable and sleep act on the output without waiting for a clock.

Reads come out either one cycle after capture (flow-through) or two cycles after capture, through an extra output register (pipelined). The drive turns off on single-cycle-deselect timing: a non-read capture silences the output one stage sooner than read data travels. The bus is modelled as separate data-in and data-out lanes plus a drive flag. All ports are plain control and data pins. There is no handshake, and the block never applies back-pressure: a command is accepted every cycle.

Top module: `sburst_sram`

## Requirements
- R1: After reset the drive flag `dout_en` is low and every array word reads as zero.
- R2: A start on the controller strobe (`strb_ctl_n` low) takes effect only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it deselects: nothing is written, no read is due and the burst ends. `ce2` and `ce3_n` have no effect on cycles that are not start cycles.
- R3: When `ce1_n`=0, a start on the processor strobe (`strb_cpu_n` low) is always a read, whatever the write controls say. When `ce1_n`=1, the processor strobe is ignored and the cycle behaves as if that strobe were high.
- R4: A start loads the beat offset from `addr[1:0]`. Each cycle with both strobes high and `burst_step_n`=0 advances the beat. Beat i uses low bits `(s+i) mod 4` when `lin_order_n`=0 and `s xor i` when `lin_order_n`=1. The fifth beat returns to s, and the upper address bits stay fixed.
- R5: A cycle with both strobes high and `burst_step_n`=1 keeps the current address. The direction, read or write, is taken again each cycle, so a processor-strobe read followed by such a cycle with a write control active writes the start address.
- R6: `wr_all_n`=0 writes all four lanes, whatever `lane_n` holds. Otherwise, when `wr_byte_n`=0, each lane i whose `lane_n[i]`=0 is written, where lane i is `din[8i+7:8i]`. If neither write control is active, the cycle is a read.
- R7: With `pipe_mode`=0, read data and the drive appear in the cycle after the capturing edge. With `pipe_mode`=1 they appear one cycle later. A read drives all four lanes.
- R8: After an edge that captures a write, the drive is off in the following cycle in both output modes.
- R9: With `pipe_mode`=1, the drive is off in any cycle whose most recent edge captured something other than a read (deselect, write or idle), even if the edge before it captured a read.
- R10: `oe_n`=1 forces `dout_en` low at once. `oe_n`=0 only drives when a read result is due.
- R11: `sleep`=1 forces `dout_en` low at once. Every command is ignored while `sleep` is high at an edge and for the first WAKE_CYC (default 2) edges after it falls. Memory contents are kept.
- R12: A read of an address returns the bytes most recently written there, with lanes that were not written unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address; low two bits preset the beat |
| din | input | 32 | Write data, four byte lanes |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high, sampled at starts only |
| ce3_n | input | 1 | Chip enable, active low, sampled at starts only |
| strb_cpu_n | input | 1 | Processor-side start strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller-side start strobe, active low |
| burst_step_n | input | 1 | Advance the beat when low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Standby request, active high |
| lin_order_n | input | 1 | 0 linear beat order, 1 interleaved |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | Drive flag for the modelled bus |

## Verification
The bench builds the block with ADDR_W=8 and WAKE_CYC=2. The 4-beat counter makes it practical to sweep every start offset against both beat orders and both output modes, 16 bursts in all, each written to and read back from its own row with a rotated start. The short wake constant lets the recovery window after sleep be walked edge by edge. Directed runs cover the lane-merge, enable-gating and early turn-off cases.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

  // low address bits of beat k for a burst starting at offset s
  function automatic logic [1:0] beat_lsb(input logic [1:0] s, input logic [1:0] k,
                                          input logic lin);
    return lin ? 2'(s + k) : (s ^ k);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
`timescale 1ns/1ps
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NB       = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              burst_step_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [NB-1:0]     lane_n,
  input  logic              sleep,
  input  logic              lin_order_n,
  output op_e               op_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [NB-1:0]     wmask_o
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic              act_q, act_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic [WK_W-1:0]   wake_q;
  logic              dozing, cpu_go, enabled, lin, cont;
  logic [NB-1:0]     lanes_w;
  logic [ADDR_W-1:0] cur_a, nxt_a;
  op_e               op_d;

  assign lin     = !lin_order_n;
  assign dozing  = sleep || (wake_q != '0);
  assign cpu_go  = !strb_cpu_n && !ce1_n;
  assign enabled = !ce1_n && ce2 && !ce3_n;
  assign lanes_w = !wr_all_n ? {NB{1'b1}} : (!wr_byte_n ? ~lane_n : {NB{1'b0}});
  assign cur_a   = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], beat_q, lin)};
  assign nxt_a   = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], 2'(beat_q + 2'd1), lin)};
  assign cont    = act_q && !dozing && !cpu_go && strb_ctl_n && !burst_step_n;

  always_comb begin
    op_d   = OP_NONE;
    acc_d_default();
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    if (dozing) begin
      act_d = 1'b0;
    end else if (cpu_go) begin
      if (enabled) begin
        op_d = OP_READ;
        acc_addr_o = addr;
        base_d = addr;
        beat_d = 2'd0;
        act_d  = 1'b1;
      end else begin
        act_d = 1'b0;
      end
    end else if (!strb_ctl_n) begin
      if (enabled) begin
        op_d = (|lanes_w) ? OP_WRITE : OP_READ;
        acc_addr_o = addr;
        base_d = addr;
        beat_d = 2'd0;
        act_d  = 1'b1;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      if (!burst_step_n) begin
        acc_addr_o = nxt_a;
        beat_d = 2'(beat_q + 2'd1);
      end
      op_d = (|lanes_w) ? OP_WRITE : OP_READ;
    end
  end

  function automatic void acc_d_default();
    acc_addr_o = cur_a;
  endfunction

  assign op_o    = op_d;
  assign wmask_o = (op_d == OP_WRITE) ? lanes_w : {NB{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
      wake_q <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      if (sleep) wake_q <= WK_W'(WAKE_CYC);
      else if (wake_q != '0) wake_q <= wake_q - 1'b1;
    end
  end

  AST_BURST_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> (acc_addr_o[1:0] != cur_a[1:0]) && (acc_addr_o[ADDR_W-1:2] == base_q[ADDR_W-1:2]))
    else $error("burst advance did not move within its row"); // R4
  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q != '0) |-> (op_o == OP_NONE))
    else $error("command accepted during wake recovery"); // R11
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
  parameter int ADDR_W = 8,
  parameter int NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     we,
  input  logic              rd_en,
  input  logic [8*NB-1:0]   din,
  output logic [8*NB-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        rd_b <= 8'h00;
      end else begin
        if (we[g]) mem[addr] <= din[8*g +: 8];
        if (rd_en) rd_b <= mem[addr];
      end
    end
    assign rd_data[8*g +: 8] = rd_b;
  end

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (we != '0)))
    else $error("read and write captured together"); // R6
endmodule

// File: rtl/sbs_outpath.sv
`timescale 1ns/1ps
module sbs_outpath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic [DW-1:0] s1_data,
  input  logic          pipe_mode,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          s1v, s2v, drv_raw;
  logic [DW-1:0] s2_data, sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1v     <= 1'b0;
      s2v     <= 1'b0;
      s2_data <= '0;
    end else begin
      s1v     <= rd_fire;
      s2v     <= s1v;
      s2_data <= s1_data;
    end
  end

  // turn-off follows the latest capture (stage 1) in both modes
  assign drv_raw = pipe_mode ? (s1v && s2v) : s1v;
  assign sel     = pipe_mode ? s2_data : s1_data;
  assign dout_en = drv_raw && !oe_n && !sleep;
  assign dout    = dout_en ? sel : '0;

  AST_FLOW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && drv_raw) |-> $past(rd_fire))
    else $error("flow-through drive without a read"); // R7
  AST_PIPE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && drv_raw) |-> $past(rd_fire, 2))
    else $error("pipelined drive without a read two edges back"); // R7
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !drv_raw)
    else $error("drive active after a write capture"); // R8
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       din,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              burst_step_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [3:0]        lane_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              lin_order_n,
  input  logic              pipe_mode,
  output logic [31:0]       dout,
  output logic              dout_en
);
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  op_e               op;
  logic [ADDR_W-1:0] acc_addr;
  logic [NB-1:0]     wmask;
  logic [DW-1:0]     s1_data;
  logic              rd_fire, wr_fire;

  sbs_ctrl #(.ADDR_W(ADDR_W), .NB(NB), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .burst_step_n(burst_step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .sleep(sleep),
    .lin_order_n(lin_order_n), .op_o(op), .acc_addr_o(acc_addr), .wmask_o(wmask)
  );

  assign rd_fire = (op == OP_READ);
  assign wr_fire = (op == OP_WRITE);

  sbs_array #(.ADDR_W(ADDR_W), .NB(NB)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .we(wmask), .rd_en(rd_fire),
    .din(din), .rd_data(s1_data)
  );

  sbs_outpath #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire), .s1_data(s1_data),
    .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  AST_CPU_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !ce1_n) |-> (wmask == '0))
    else $error("processor-strobe start wrote the array"); // R3
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (wmask == '0))
    else $error("write accepted while asleep"); // R11
  AST_OFF_CE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl_n && strb_cpu_n && (ce3_n || !ce2)) |-> (wmask == '0))
    else $error("disabled controller start wrote the array"); // R2
endmodule

// File: tb/sburst_sram_bench.sv
`timescale 1ns/1ps
module sburst_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] din;
  logic        ce1_n, ce2, ce3_n, strb_cpu_n, strb_ctl_n, burst_step_n;
  logic        wr_all_n, wr_byte_n, oe_n, sleep, lin_order_n, pipe_mode;
  logic [3:0]  lane_n;
  logic [31:0] dout;
  logic        dout_en;

  always #4 clk = ~clk;

  sburst_sram #(.ADDR_W(8), .WAKE_CYC(2)) u_sburst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .burst_step_n(burst_step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .oe_n(oe_n), .sleep(sleep), .lin_order_n(lin_order_n),
    .pipe_mode(pipe_mode), .dout(dout), .dout_en(dout_en)
  );

  logic [31:0] ref_mem [256];
  int          total = 0, bad = 0;
  bit          done = 0;
  bit          h_lr = 0, h_pr = 0;
  logic [31:0] h_lv = '0, h_pv = '0;
  logic [7:0]  b_addr = '0;
  int          b_i = 0;

  function automatic logic [1:0] blsb(input logic [1:0] s, input int i);
    logic [1:0] k = 2'(i);
    return lin_order_n ? (s ^ k) : 2'(s + k);
  endfunction

  function automatic logic [7:0] cur_a();
    return {b_addr[7:2], blsb(b_addr[1:0], b_i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    bit en;
    logic [31:0] v;
    en = (pipe_mode ? (h_lr && h_pr) : h_lr) && !oe_n && !sleep;
    v  = pipe_mode ? h_pv : h_lv;
    chk(dout_en === en, {tag, " drive"}, {31'd0, dout_en}, {31'd0, en});
    if (en) chk(dout === v, {tag, " data"}, dout, v);
  endtask

  task automatic tick(input bit rd, input logic [31:0] v, input string tag);
    @(posedge clk);
    h_pr = h_lr; h_pv = h_lv; h_lr = rd; h_lv = v;
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle_in();
    strb_cpu_n = 1; strb_ctl_n = 1; burst_step_n = 1; wr_all_n = 1; wr_byte_n = 1;
    lane_n = 4'hF; ce1_n = 0; ce2 = 1; ce3_n = 0; addr = '0; din = '0;
  endtask

  task automatic wr_ref(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
    for (int k = 0; k < 4; k++) if (m[k]) ref_mem[a][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic set_wr(input logic [31:0] d, input logic [3:0] m, input bit all);
    din = d;
    if (all) wr_all_n = 0;
    else begin wr_byte_n = 0; lane_n = ~m; end
  endtask

  task automatic ctl_rd(input logic [7:0] a, input string tag);
    idle_in(); strb_ctl_n = 0; addr = a; b_addr = a; b_i = 0;
    tick(1, ref_mem[a], tag);
  endtask

  task automatic ctl_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m,
                        input bit all, input string tag);
    idle_in(); strb_ctl_n = 0; addr = a; set_wr(d, m, all); b_addr = a; b_i = 0;
    tick(0, '0, tag);
    wr_ref(a, d, all ? 4'hF : m);
  endtask

  task automatic cpu_rd(input logic [7:0] a, input bit wa, input string tag);
    idle_in(); strb_cpu_n = 0; addr = a; wr_all_n = !wa; din = 32'hDEADBEEF;
    b_addr = a; b_i = 0;
    tick(1, ref_mem[a], tag);
  endtask

  task automatic step_rd(input bit adv, input bit odd, input string tag);
    idle_in();
    if (adv) b_i++;
    burst_step_n = !adv;
    if (odd) begin strb_cpu_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; end
    tick(1, ref_mem[cur_a()], tag);
  endtask

  task automatic step_wr(input bit adv, input logic [31:0] d, input logic [3:0] m,
                         input bit all, input string tag);
    idle_in();
    if (adv) b_i++;
    burst_step_n = !adv; set_wr(d, m, all);
    tick(0, '0, tag);
    wr_ref(cur_a(), d, all ? 4'hF : m);
  endtask

  task automatic desel(input string tag);
    idle_in(); strb_ctl_n = 0; ce2 = 0;
    tick(0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    idle_in(); oe_n = 0; sleep = 0; lin_order_n = 1; pipe_mode = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_out("R1 reset drive");
    ctl_rd(8'h33, "R1 zero array");
    desel("R1");

    // sweep: every start offset x beat order x output mode
    for (int o = 0; o < 2; o++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 4; s++) begin
          logic [7:0] row;
          lin_order_n = o[0]; pipe_mode = p[0];
          row = 8'(64 + o*32 + p*16 + s*4);
          ctl_wr(row | 8'(s), {8'(o*8+p*4+s), 8'd0, row, 8'hC3}, 4'hF, 1, "R6 sweep write");
          for (int k = 1; k < 4; k++)
            step_wr(1, {8'(o*8+p*4+s), 8'(k), row, 8'hC3 ^ 8'(k*17)}, 4'hF, 0, "R4 burst write");
          desel("R8 after write");
          ctl_rd(row | 8'((s + 1) % 4), "R7 start beat");
          for (int k = 1; k < 5; k++) step_rd(1, 0, "R4 beat and wrap");
          step_rd(0, 0, "R5 suspend");
          desel("R9 early off");
        end

    lin_order_n = 1; pipe_mode = 0;
    ctl_wr(8'h10, 32'h11223344, 4'hF, 1, "R6 global");
    ctl_wr(8'h10, 32'hAABBCCDD, 4'b0101, 0, "R6 lanes");
    ctl_rd(8'h10, "R12 merged lanes");
    ctl_wr(8'h10, 32'h55667788, 4'h0, 1, "R6 global over lanes");
    ctl_rd(8'h10, "R12 global readback");
    idle_in(); strb_ctl_n = 0; addr = 8'h10; lane_n = 4'h0; din = 32'hFFFFFFFF;
    b_addr = 8'h10; b_i = 0;
    tick(1, ref_mem[8'h10], "R6 no write control is read");
    ctl_rd(8'h10, "R6 unchanged");
    desel("R2");

    idle_in(); strb_ctl_n = 0; ce3_n = 1; addr = 8'h10; set_wr(32'h0, 4'hF, 1);
    tick(0, '0, "R2 ce3 off start");
    idle_in(); strb_ctl_n = 0; ce1_n = 1; addr = 8'h10; set_wr(32'h0, 4'hF, 1);
    tick(0, '0, "R2 ce1 off start");
    ctl_rd(8'h10, "R2 no write happened");
    step_rd(1, 1, "R2 R3 enables ignored mid-burst");
    desel("R2");

    cpu_rd(8'h10, 1, "R3 cpu start reads");
    step_rd(0, 0, "R3 no write");
    desel("R3");
    cpu_rd(8'h21, 0, "R3 cpu start");
    step_wr(0, 32'hCAFEF00D, 4'hF, 1, "R5 suspend write");
    desel("R5");
    ctl_rd(8'h21, "R5 R12 readback");
    desel("R5");

    pipe_mode = 1;
    ctl_rd(8'h21, "R9 read");
    ctl_wr(8'h22, 32'h01020304, 4'hF, 1, "R8 R9 write after read");
    desel("R8");
    ctl_rd(8'h22, "R7 pipelined");
    step_rd(0, 0, "R7 pipelined data");
    desel("R9");
    pipe_mode = 0;

    ctl_rd(8'h22, "R10 read");
    oe_n = 1; #1; check_out("R10 oe high off");
    oe_n = 0; #1; check_out("R10 oe low back on");
    step_rd(0, 0, "R10");
    desel("R10");

    ctl_wr(8'h30, 32'h0BADCAFE, 4'hF, 1, "R11 prewrite");
    ctl_rd(8'h30, "R11 pre");
    sleep = 1; #1; check_out("R11 async off");
    idle_in(); strb_ctl_n = 0; addr = 8'h30; set_wr(32'hFFFFFFFF, 4'hF, 1);
    tick(0, '0, "R11 write asleep ignored");
    sleep = 0;
    idle_in(); strb_ctl_n = 0; addr = 8'h30;
    tick(0, '0, "R11 recovery edge one");
    idle_in(); strb_ctl_n = 0; addr = 8'h30; set_wr(32'hFFFFFFFF, 4'hF, 1);
    tick(0, '0, "R11 recovery edge two");
    ctl_rd(8'h30, "R11 contents kept");
    desel("R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule